// File: doc/BRIEF.md
# Basic Block Reuse Buffer

The block keeps a small history of recently executed basic blocks. Each stored block is keyed by its start address. Its inputs are recorded as register (index, value) pairs and memory (word address, loaded data) pairs. Its effects are recorded as register writes and memory writes. Before a block runs again, the front end presents the block address together with the input pairs it has gathered for that block. If the stored block's inputs all agree with the presented ones, the buffer declares a hit. It then plays back the stored writes so that the block itself need not execute. On any disagreement the block executes normally.

The commit stage fills the buffer through an insert port. Each entry has a fixed number of slots: four input registers, four memory reads, five output registers and two memory writes. A block that needs more slots than that in any class is refused. The buffer has eight entries, searched in full on the start address. A new block goes into a free entry, or failing that into the least recently used one. Writes are played back one per cycle on a valid/ready handshake. New lookups wait while a playback is under way.

Top module: `block_reuse_buf`

## Requirements
- R1: An insert whose input-register count is at most 4, memory-read count at most 4, output-register count at most 5 and memory-write count at most 2 is stored, and `ins_reject` stays low. If any count is over its limit, `ins_reject` is high in the same cycle and nothing is stored. Slot i of a class is in use when i is less than that class's count.
- R2: A lookup is accepted when `lk_valid` and `lk_ready` are both high. One cycle later `res_valid` pulses, and `res_hit` is 1 exactly when four conditions hold: an entry has the same start address, the input-register count matches, the memory-read count matches, and every slot in use matches its register index and value, or its memory address and data.
- R3: A difference in any single in-use input field (register index, register value, memory address, memory data), or in either input count, gives a miss.
- R4: After a hit, the writes appear on the replay port one per accepted handshake. Register writes come first, in slot order, with `rp_is_mem`=0. Memory writes follow, in slot order, with `rp_is_mem`=1. `rp_last` marks the final item.
- R5: While a playback is pending, `lk_ready` is low and no lookup is accepted. While `rp_ready` is low, the replay item holds steady.
- R6: There are 8 entries. A new block goes into a free entry if one exists, otherwise into the least recently used entry, where both inserts and hits count as use.
- R7: Inserting a block whose start address is already stored replaces that entry's contents.
- R8: A hit on a block with no recorded writes gives `res_hit`=1, produces no replay item, and leaves `lk_ready` high.
- R9: A lookup presenting more input registers or memory reads than an entry can hold misses.
- R10: After reset all entries are empty, `lk_ready` is 1, and `res_valid` and `rp_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_valid | input | 1 | Lookup request |
| lk_ready | output | 1 | Lookup can be accepted |
| lk_tag | input | 32 | Block start address |
| lk_nrin | input | 3 | Presented input-register count |
| lk_rin_idx | input | 20 | Input register indices, slot i at bits 5i+4:5i |
| lk_rin_val | input | 128 | Input register values, slot i at bits 32i+31:32i |
| lk_nmrd | input | 3 | Presented memory-read count |
| lk_mrd_addr | input | 128 | Memory read word addresses |
| lk_mrd_data | input | 128 | Current memory data at those addresses |
| res_valid | output | 1 | Lookup result strobe |
| res_hit | output | 1 | Block can be skipped |
| ins_valid | input | 1 | Insert request from commit |
| ins_tag | input | 32 | Block start address |
| ins_nrin | input | 3 | Input-register count |
| ins_rin_idx | input | 20 | Input register indices |
| ins_rin_val | input | 128 | Input register values |
| ins_nmrd | input | 3 | Memory-read count |
| ins_mrd_addr | input | 128 | Memory read addresses |
| ins_mrd_data | input | 128 | Memory read data |
| ins_nrout | input | 3 | Output-register count |
| ins_rout_idx | input | 25 | Output register indices |
| ins_rout_val | input | 160 | Output register values |
| ins_nmwr | input | 3 | Memory-write count |
| ins_mwr_addr | input | 64 | Memory write addresses |
| ins_mwr_data | input | 64 | Memory write data |
| ins_reject | output | 1 | Insert refused for exceeding a slot limit |
| rp_valid | output | 1 | Replay item present |
| rp_ready | input | 1 | Replay item taken |
| rp_is_mem | output | 1 | 0 register write, 1 memory write |
| rp_ridx | output | 5 | Register index (register writes) |
| rp_addr | output | 32 | Word address (memory writes) |
| rp_data | output | 32 | Write value |
| rp_last | output | 1 | Final replay item |

## Verification
The bench sweeps single-field corruptions over every in-use input slot, and also changes the input counts by one. A matcher that skipped a field, or compared only the slots in use without comparing the counts, would report false hits. It probes each slot class one above and exactly at its limit. An off-by-one limit test would either store an oversized block or refuse a full-size one. The bench fills all eight entries, touches the oldest, and then evicts. Age counters that are not refreshed on a hit would throw out the block that was just used. Finally, it stalls the replay port while pushing new lookups. A design that let a lookup through or moved the replay item during the stall would lose writes or report extra results.

// File: rtl/brb_pkg.sv
package brb_pkg;
    localparam int unsigned DW     = 32;
    localparam int unsigned AW     = 32;
    localparam int unsigned RW     = 5;
    localparam int unsigned N_RIN  = 4;
    localparam int unsigned N_MRD  = 4;
    localparam int unsigned N_ROUT = 5;
    localparam int unsigned N_MWR  = 2;
    localparam int unsigned CW     = 3;
    localparam int unsigned ROUT_IW = (N_ROUT > 1) ? $clog2(N_ROUT) : 1;
    localparam int unsigned MWR_IW  = (N_MWR > 1) ? $clog2(N_MWR) : 1;

    typedef struct packed {
        logic                          vld;
        logic [AW-1:0]                 tag;
        logic [N_RIN-1:0]              rin_msk;
        logic [N_RIN-1:0][RW-1:0]      rin_idx;
        logic [N_RIN-1:0][DW-1:0]      rin_val;
        logic [N_MRD-1:0]              mrd_msk;
        logic [N_MRD-1:0][AW-1:0]      mrd_addr;
        logic [N_MRD-1:0][DW-1:0]      mrd_data;
        logic [N_ROUT-1:0]             rout_msk;
        logic [N_ROUT-1:0][RW-1:0]     rout_idx;
        logic [N_ROUT-1:0][DW-1:0]     rout_val;
        logic [N_MWR-1:0]              mwr_msk;
        logic [N_MWR-1:0][AW-1:0]      mwr_addr;
        logic [N_MWR-1:0][DW-1:0]      mwr_data;
    } entry_t;

    typedef struct packed {
        logic          is_mem;
        logic [RW-1:0] ridx;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } wr_item_t;

    // prefix mask with the low c bits set
    function automatic logic [7:0] cnt2msk(input logic [CW-1:0] c);
        logic [7:0] m;
        for (int i = 0; i < 8; i++) m[i] = (i < int'(c));
        return m;
    endfunction
endpackage

// File: rtl/brb_entry_match.sv
module brb_entry_match
    import brb_pkg::*;
(
    input  logic                     e_vld,
    input  logic [AW-1:0]            e_tag,
    input  logic [N_RIN-1:0]         e_rmsk,
    input  logic [N_RIN-1:0][RW-1:0] e_ridx,
    input  logic [N_RIN-1:0][DW-1:0] e_rval,
    input  logic [N_MRD-1:0]         e_mmsk,
    input  logic [N_MRD-1:0][AW-1:0] e_maddr,
    input  logic [N_MRD-1:0][DW-1:0] e_mdata,
    input  logic [AW-1:0]            q_tag,
    input  logic [N_RIN-1:0]         q_rmsk,
    input  logic [N_RIN-1:0][RW-1:0] q_ridx,
    input  logic [N_RIN-1:0][DW-1:0] q_rval,
    input  logic [N_MRD-1:0]         q_mmsk,
    input  logic [N_MRD-1:0][AW-1:0] q_maddr,
    input  logic [N_MRD-1:0][DW-1:0] q_mdata,
    output logic                     tag_hit,
    output logic                     full_hit
);
    logic [N_RIN-1:0] reg_ok;
    logic [N_MRD-1:0] mem_ok;

    for (genvar i = 0; i < N_RIN; i++) begin : g_reg
        assign reg_ok[i] = !e_rmsk[i] || (e_ridx[i] == q_ridx[i] && e_rval[i] == q_rval[i]);
    end
    for (genvar i = 0; i < N_MRD; i++) begin : g_mem
        assign mem_ok[i] = !e_mmsk[i] || (e_maddr[i] == q_maddr[i] && e_mdata[i] == q_mdata[i]);
    end

    assign tag_hit  = e_vld && (e_tag == q_tag);
    assign full_hit = tag_hit && (e_rmsk == q_rmsk) && (e_mmsk == q_mmsk)
                    && (&reg_ok) && (&mem_ok);
endmodule

// File: rtl/brb_lru.sv
module brb_lru #(
    parameter int unsigned NUM_ENT = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       touch_en,
    input  logic [$clog2(NUM_ENT)-1:0] touch_idx,
    input  logic [NUM_ENT-1:0]         vld_vec,
    output logic [$clog2(NUM_ENT)-1:0] victim
);
    localparam int unsigned IW = $clog2(NUM_ENT);

    logic [NUM_ENT-1:0][IW-1:0] age;
    logic [NUM_ENT-1:0]         oldest;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_ENT; i++) age[i] <= IW'(i);
        end else if (touch_en) begin
            for (int i = 0; i < NUM_ENT; i++) begin
                if (touch_idx == IW'(i))          age[i] <= '0;
                else if (age[i] < age[touch_idx]) age[i] <= age[i] + 1'b1;
            end
        end
    end

    for (genvar i = 0; i < NUM_ENT; i++) begin : g_old
        assign oldest[i] = (age[i] == IW'(NUM_ENT - 1));
    end

    always_comb begin
        logic found;
        found  = 1'b0;
        victim = '0;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (!vld_vec[i] && !found) begin
                victim = IW'(i);
                found  = 1'b1;
            end
        end
        if (!found) begin
            for (int i = 0; i < NUM_ENT; i++) if (oldest[i]) victim = IW'(i);
        end
    end

    // ages stay a permutation: exactly one entry is the oldest
    assert_lru_oldest_unique_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot(oldest));
    assert_victim_free_or_old_R6: assert property (@(posedge clk) disable iff (rst)
        (!vld_vec[victim] || oldest[victim]));
endmodule

// File: rtl/brb_replay.sv
module brb_replay
    import brb_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      load,
    input  logic [N_ROUT-1:0]         ld_rmsk,
    input  logic [N_ROUT-1:0][RW-1:0] ld_ridx,
    input  logic [N_ROUT-1:0][DW-1:0] ld_rval,
    input  logic [N_MWR-1:0]          ld_mmsk,
    input  logic [N_MWR-1:0][AW-1:0]  ld_maddr,
    input  logic [N_MWR-1:0][DW-1:0]  ld_mdata,
    input  logic                      rp_ready,
    output logic                      busy,
    output wr_item_t                  item,
    output logic                      last
);
    logic [N_ROUT-1:0][RW-1:0] ridx_q;
    logic [N_ROUT-1:0][DW-1:0] rval_q;
    logic [N_MWR-1:0][AW-1:0]  maddr_q;
    logic [N_MWR-1:0][DW-1:0]  mdata_q;
    logic [CW-1:0]             nreg_q, ntot_q, pos_q, mpos;
    logic [CW-1:0]             ld_nreg, ld_ntot;

    assign ld_nreg = CW'($countones(ld_rmsk));
    assign ld_ntot = ld_nreg + CW'($countones(ld_mmsk));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            pos_q   <= '0;
            nreg_q  <= '0;
            ntot_q  <= '0;
            ridx_q  <= '0;
            rval_q  <= '0;
            maddr_q <= '0;
            mdata_q <= '0;
        end else if (load) begin
            busy    <= (ld_ntot != '0);
            pos_q   <= '0;
            nreg_q  <= ld_nreg;
            ntot_q  <= ld_ntot;
            ridx_q  <= ld_ridx;
            rval_q  <= ld_rval;
            maddr_q <= ld_maddr;
            mdata_q <= ld_mdata;
        end else if (busy && rp_ready) begin
            if (last) busy  <= 1'b0;
            else      pos_q <= pos_q + 1'b1;
        end
    end

    assign mpos = pos_q - nreg_q;
    assign last = busy && (pos_q == ntot_q - 1'b1);

    always_comb begin
        item = '0;
        if (pos_q < nreg_q) begin
            item.is_mem = 1'b0;
            item.ridx   = ridx_q[pos_q[ROUT_IW-1:0]];
            item.data   = rval_q[pos_q[ROUT_IW-1:0]];
        end else begin
            item.is_mem = 1'b1;
            item.addr   = maddr_q[mpos[MWR_IW-1:0]];
            item.data   = mdata_q[mpos[MWR_IW-1:0]];
        end
    end

    assert_hold_while_stalled_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && !rp_ready) |=> (busy && $stable(item)));
    assert_regs_before_mem_R4: assert property (@(posedge clk) disable iff (rst)
        (busy && rp_ready && item.is_mem && !last) |=> item.is_mem);
    assert_last_ends_R4: assert property (@(posedge clk) disable iff (rst)
        (busy && rp_ready && last) |=> !busy);
endmodule

// File: rtl/block_reuse_buf.sv
module block_reuse_buf
    import brb_pkg::*;
#(
    parameter int unsigned NUM_ENT = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  lk_valid,
    output logic                  lk_ready,
    input  logic [31:0]           lk_tag,
    input  logic [2:0]            lk_nrin,
    input  logic [19:0]           lk_rin_idx,
    input  logic [127:0]          lk_rin_val,
    input  logic [2:0]            lk_nmrd,
    input  logic [127:0]          lk_mrd_addr,
    input  logic [127:0]          lk_mrd_data,
    output logic                  res_valid,
    output logic                  res_hit,
    input  logic                  ins_valid,
    input  logic [31:0]           ins_tag,
    input  logic [2:0]            ins_nrin,
    input  logic [19:0]           ins_rin_idx,
    input  logic [127:0]          ins_rin_val,
    input  logic [2:0]            ins_nmrd,
    input  logic [127:0]          ins_mrd_addr,
    input  logic [127:0]          ins_mrd_data,
    input  logic [2:0]            ins_nrout,
    input  logic [24:0]           ins_rout_idx,
    input  logic [159:0]          ins_rout_val,
    input  logic [2:0]            ins_nmwr,
    input  logic [63:0]           ins_mwr_addr,
    input  logic [63:0]           ins_mwr_data,
    output logic                  ins_reject,
    output logic                  rp_valid,
    input  logic                  rp_ready,
    output logic                  rp_is_mem,
    output logic [4:0]            rp_ridx,
    output logic [31:0]           rp_addr,
    output logic [31:0]           rp_data,
    output logic                  rp_last
);
    localparam int unsigned IW = $clog2(NUM_ENT);

    entry_t             ents [NUM_ENT];
    entry_t             new_ent;
    logic [NUM_ENT-1:0] vld_vec, tag_vec, hit_vec;
    logic [N_RIN-1:0]   q_rmsk;
    logic [N_MRD-1:0]   q_mmsk;
    logic [7:0]         m_rin, m_mrd, m_irin, m_imrd, m_irout, m_imwr;
    logic               lk_ok, lk_acc, hit_any, ins_bad, ins_do, tag_any, busy;
    logic [IW-1:0]      hit_idx, tag_idx, victim, tgt;
    wr_item_t           item;

    // ---------------- lookup side ----------------
    assign m_rin  = cnt2msk(lk_nrin);
    assign m_mrd  = cnt2msk(lk_nmrd);
    assign q_rmsk = m_rin[N_RIN-1:0];
    assign q_mmsk = m_mrd[N_MRD-1:0];
    assign lk_ok  = (lk_nrin <= CW'(N_RIN)) && (lk_nmrd <= CW'(N_MRD));
    assign lk_ready = !busy;
    assign lk_acc   = lk_valid && lk_ready;

    for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
        assign vld_vec[e] = ents[e].vld;
        brb_entry_match u_match (
            .e_vld   (ents[e].vld),
            .e_tag   (ents[e].tag),
            .e_rmsk  (ents[e].rin_msk),
            .e_ridx  (ents[e].rin_idx),
            .e_rval  (ents[e].rin_val),
            .e_mmsk  (ents[e].mrd_msk),
            .e_maddr (ents[e].mrd_addr),
            .e_mdata (ents[e].mrd_data),
            .q_tag   (lk_tag),
            .q_rmsk  (q_rmsk),
            .q_ridx  (lk_rin_idx),
            .q_rval  (lk_rin_val),
            .q_mmsk  (q_mmsk),
            .q_maddr (lk_mrd_addr),
            .q_mdata (lk_mrd_data),
            .tag_hit (),
            .full_hit(hit_vec[e])
        );
        // separate tag compare for the insert port
        brb_entry_match u_itag (
            .e_vld   (ents[e].vld),
            .e_tag   (ents[e].tag),
            .e_rmsk  ('0),
            .e_ridx  ('0),
            .e_rval  ('0),
            .e_mmsk  ('0),
            .e_maddr ('0),
            .e_mdata ('0),
            .q_tag   (ins_tag),
            .q_rmsk  ('0),
            .q_ridx  ('0),
            .q_rval  ('0),
            .q_mmsk  ('0),
            .q_maddr ('0),
            .q_mdata ('0),
            .tag_hit (tag_vec[e]),
            .full_hit()
        );
    end

    always_comb begin
        hit_idx = '0;
        tag_idx = '0;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (hit_vec[i]) hit_idx = IW'(i);
            if (tag_vec[i]) tag_idx = IW'(i);
        end
    end

    assign hit_any = lk_acc && lk_ok && (|hit_vec);
    assign tag_any = |tag_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
        end else begin
            res_valid <= lk_acc;
            res_hit   <= hit_any;
        end
    end

    // ---------------- insert side ----------------
    assign ins_bad = (ins_nrin > CW'(N_RIN)) || (ins_nmrd > CW'(N_MRD))
                  || (ins_nrout > CW'(N_ROUT)) || (ins_nmwr > CW'(N_MWR));
    assign ins_reject = ins_valid && ins_bad;
    assign ins_do     = ins_valid && !ins_bad;
    assign tgt        = tag_any ? tag_idx : victim;

    assign m_irin  = cnt2msk(ins_nrin);
    assign m_imrd  = cnt2msk(ins_nmrd);
    assign m_irout = cnt2msk(ins_nrout);
    assign m_imwr  = cnt2msk(ins_nmwr);

    always_comb begin
        new_ent          = '0;
        new_ent.vld      = 1'b1;
        new_ent.tag      = ins_tag;
        new_ent.rin_msk  = m_irin[N_RIN-1:0];
        new_ent.rin_idx  = ins_rin_idx;
        new_ent.rin_val  = ins_rin_val;
        new_ent.mrd_msk  = m_imrd[N_MRD-1:0];
        new_ent.mrd_addr = ins_mrd_addr;
        new_ent.mrd_data = ins_mrd_data;
        new_ent.rout_msk = m_irout[N_ROUT-1:0];
        new_ent.rout_idx = ins_rout_idx;
        new_ent.rout_val = ins_rout_val;
        new_ent.mwr_msk  = m_imwr[N_MWR-1:0];
        new_ent.mwr_addr = ins_mwr_addr;
        new_ent.mwr_data = ins_mwr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_ENT; i++) ents[i] <= '0;
        end else if (ins_do) begin
            ents[tgt] <= new_ent;
        end
    end

    brb_lru #(.NUM_ENT(NUM_ENT)) u_lru (
        .clk      (clk),
        .rst      (rst),
        .touch_en (ins_do || hit_any),
        .touch_idx(ins_do ? tgt : hit_idx),
        .vld_vec  (vld_vec),
        .victim   (victim)
    );

    // ---------------- replay side ----------------
    brb_replay u_replay (
        .clk     (clk),
        .rst     (rst),
        .load    (hit_any),
        .ld_rmsk (ents[hit_idx].rout_msk),
        .ld_ridx (ents[hit_idx].rout_idx),
        .ld_rval (ents[hit_idx].rout_val),
        .ld_mmsk (ents[hit_idx].mwr_msk),
        .ld_maddr(ents[hit_idx].mwr_addr),
        .ld_mdata(ents[hit_idx].mwr_data),
        .rp_ready(rp_ready),
        .busy    (busy),
        .item    (item),
        .last    (rp_last)
    );

    assign rp_valid  = busy;
    assign rp_is_mem = item.is_mem;
    assign rp_ridx   = item.ridx;
    assign rp_addr   = item.addr;
    assign rp_data   = item.data;

    assert_single_hit_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));
    assert_reject_no_store_R1: assert property (@(posedge clk) disable iff (rst)
        ins_reject |=> $stable(vld_vec));
    assert_stall_no_result_R5: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && !lk_ready) |=> !res_valid);
    assert_no_result_unasked_R2: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !res_valid);
endmodule

// File: tb/test_block_reuse_buf.sv
module test_block_reuse_buf;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic         lk_valid = 0, lk_ready, res_valid, res_hit;
    logic [31:0]  lk_tag = 0;
    logic [2:0]   lk_nrin = 0, lk_nmrd = 0;
    logic [19:0]  lk_rin_idx = 0;
    logic [127:0] lk_rin_val = 0, lk_mrd_addr = 0, lk_mrd_data = 0;
    logic         ins_valid = 0, ins_reject;
    logic [31:0]  ins_tag = 0;
    logic [2:0]   ins_nrin = 0, ins_nmrd = 0, ins_nrout = 0, ins_nmwr = 0;
    logic [19:0]  ins_rin_idx = 0;
    logic [127:0] ins_rin_val = 0, ins_mrd_addr = 0, ins_mrd_data = 0;
    logic [24:0]  ins_rout_idx = 0;
    logic [159:0] ins_rout_val = 0;
    logic [63:0]  ins_mwr_addr = 0, ins_mwr_data = 0;
    logic         rp_valid, rp_ready = 1, rp_is_mem, rp_last;
    logic [4:0]   rp_ridx;
    logic [31:0]  rp_addr, rp_data;

    int checks = 0, errors = 0;

    block_reuse_buf i_block_reuse_buf (.*);

    function automatic logic [4:0]  f_ri (int t, int i);         return 5'((t*3 + i) % 32);          endfunction
    function automatic logic [31:0] f_rv (int t, int i, int s);  return 32'(t*65537 + i + s);        endfunction
    function automatic logic [31:0] f_ma (int t, int i);         return 32'(t*64 + i);               endfunction
    function automatic logic [31:0] f_md (int t, int i, int s);  return 32'(t*7919 + i*13 + s);      endfunction
    function automatic logic [4:0]  f_oi (int t, int j);         return 5'((t + j + 7) % 32);        endfunction
    function automatic logic [31:0] f_ov (int t, int j, int s);  return 32'(t*100 + j + s*7);        endfunction
    function automatic logic [31:0] f_wa (int t, int j);         return 32'(32768 + t*4 + j);        endfunction
    function automatic logic [31:0] f_wd (int t, int j, int s);  return 32'(t*11 + j*257 + s);       endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // drives an insert at a negedge; returns at the next negedge
    task automatic do_insert(input int t, input int nri, input int nmr, input int nro,
                             input int nmw, input int s, input bit exp_rej, input string req);
        ins_tag = 32'(t);
        ins_nrin = 3'(nri); ins_nmrd = 3'(nmr); ins_nrout = 3'(nro); ins_nmwr = 3'(nmw);
        for (int i = 0; i < 4; i++) begin
            ins_rin_idx[i*5 +: 5]   = f_ri(t, i);
            ins_rin_val[i*32 +: 32] = f_rv(t, i, s);
            ins_mrd_addr[i*32 +: 32] = f_ma(t, i);
            ins_mrd_data[i*32 +: 32] = f_md(t, i, s);
        end
        for (int j = 0; j < 5; j++) begin
            ins_rout_idx[j*5 +: 5]   = f_oi(t, j);
            ins_rout_val[j*32 +: 32] = f_ov(t, j, s);
        end
        for (int j = 0; j < 2; j++) begin
            ins_mwr_addr[j*32 +: 32] = f_wa(t, j);
            ins_mwr_data[j*32 +: 32] = f_wd(t, j, s);
        end
        ins_valid = 1;
        #1;
        chk(ins_reject == exp_rej, req, 64'(ins_reject), 64'(exp_rej));
        @(negedge clk);
        ins_valid = 0;
    endtask

    // kind: 0 none, 1 reg idx, 2 reg val, 3 mem addr, 4 mem data, 5 one extra reg, 6 one fewer mem read
    task automatic set_lookup(input int t, input int nri, input int nmr, input int s,
                              input int kind, input int slot);
        int cr, cm;
        cr = (kind == 5) ? nri + 1 : nri;
        cm = (kind == 6) ? nmr - 1 : nmr;
        lk_tag = 32'(t); lk_nrin = 3'(cr); lk_nmrd = 3'(cm);
        lk_rin_idx = '0; lk_rin_val = '0; lk_mrd_addr = '0; lk_mrd_data = '0;
        for (int i = 0; i < 4; i++) begin
            if (i < cr) begin
                lk_rin_idx[i*5 +: 5]   = f_ri(t, i) ^ ((kind == 1 && slot == i) ? 5'd1 : 5'd0);
                lk_rin_val[i*32 +: 32] = f_rv(t, i, s) ^ ((kind == 2 && slot == i) ? 32'h8000_0000 : 32'd0);
            end
            if (i < cm) begin
                lk_mrd_addr[i*32 +: 32] = f_ma(t, i) ^ ((kind == 3 && slot == i) ? 32'd2 : 32'd0);
                lk_mrd_data[i*32 +: 32] = f_md(t, i, s) ^ ((kind == 4 && slot == i) ? 32'h100 : 32'd0);
            end
        end
    endtask

    task automatic lookup(input int t, input int nri, input int nmr, input int s,
                          input int kind, input int slot, input bit exp_hit, input string req);
        set_lookup(t, nri, nmr, s, kind, slot);
        lk_valid = 1;
        @(negedge clk);
        lk_valid = 0;
        chk(res_valid == 1'b1, req, 64'(res_valid), 64'd1);
        chk(res_hit == exp_hit, req, 64'(res_hit), 64'(exp_hit));
    endtask

    task automatic replay_check(input int t, input int nro, input int nmw, input int s, input string req);
        for (int k = 0; k < nro + nmw; k++) begin
            chk(rp_valid == 1'b1, req, 64'(rp_valid), 64'd1);
            chk(rp_last == (k == nro + nmw - 1), req, 64'(rp_last), 64'(k == nro + nmw - 1));
            if (k < nro) begin
                chk(rp_is_mem == 1'b0, req, 64'(rp_is_mem), 64'd0);
                chk(rp_ridx == f_oi(t, k), req, 64'(rp_ridx), 64'(f_oi(t, k)));
                chk(rp_data == f_ov(t, k, s), req, 64'(rp_data), 64'(f_ov(t, k, s)));
            end else begin
                chk(rp_is_mem == 1'b1, req, 64'(rp_is_mem), 64'd1);
                chk(rp_addr == f_wa(t, k - nro), req, 64'(rp_addr), 64'(f_wa(t, k - nro)));
                chk(rp_data == f_wd(t, k - nro, s), req, 64'(rp_data), 64'(f_wd(t, k - nro, s)));
            end
            @(negedge clk);
        end
        chk(rp_valid == 1'b0, req, 64'(rp_valid), 64'd0);
        chk(lk_ready == 1'b1, req, 64'(lk_ready), 64'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R10 reset state
        chk(lk_ready == 1'b1, "R10", 64'(lk_ready), 64'd1);
        chk(res_valid == 1'b0, "R10", 64'(res_valid), 64'd0);
        chk(rp_valid == 1'b0, "R10", 64'(rp_valid), 64'd0);
        lookup(5, 1, 0, 0, 0, 0, 1'b0, "R10 empty");

        // R6 fill, touch oldest, evict
        for (int t = 1; t <= 8; t++) do_insert(t, 1, 0, 1, 0, 0, 1'b0, "R1 fill");
        for (int t = 1; t <= 8; t++) begin
            lookup(t, 1, 0, 0, 0, 0, 1'b1, "R6 all present");
            replay_check(t, 1, 0, 0, "R6");
        end
        lookup(1, 1, 0, 0, 0, 0, 1'b1, "R6 touch");
        replay_check(1, 1, 0, 0, "R6");
        // least recently used now 2
        do_insert(9, 1, 0, 1, 0, 0, 1'b0, "R1");
        lookup(2, 1, 0, 0, 0, 0, 1'b0, "R6 evicted");
        lookup(9, 1, 0, 0, 0, 0, 1'b1, "R6 new");
        replay_check(9, 1, 0, 0, "R6");
        lookup(1, 1, 0, 0, 0, 0, 1'b1, "R6 kept");
        replay_check(1, 1, 0, 0, "R6");

        // R2 / R4 main block
        do_insert(20, 2, 1, 3, 2, 5, 1'b0, "R1");
        lookup(20, 2, 1, 5, 0, 0, 1'b1, "R2 exact");
        replay_check(20, 3, 2, 5, "R4 order");

        // R3 single-field mismatches
        for (int s = 0; s < 2; s++) begin
            lookup(20, 2, 1, 5, 1, s, 1'b0, "R3 reg idx");
            lookup(20, 2, 1, 5, 2, s, 1'b0, "R3 reg val");
        end
        lookup(20, 2, 1, 5, 3, 0, 1'b0, "R3 mem addr");
        lookup(20, 2, 1, 5, 4, 0, 1'b0, "R3 mem data");
        lookup(20, 2, 1, 5, 5, 0, 1'b0, "R3 extra reg");
        lookup(20, 2, 1, 5, 6, 0, 1'b0, "R3 fewer mem");
        lookup(999, 2, 1, 5, 0, 0, 1'b0, "R2 unknown tag");
        lookup(20, 5, 1, 5, 0, 0, 1'b0, "R9 oversize lookup");

        // R1 limits
        do_insert(50, 5, 0, 0, 0, 0, 1'b1, "R1 rin over");
        do_insert(51, 0, 5, 0, 0, 0, 1'b1, "R1 mrd over");
        do_insert(52, 0, 0, 6, 0, 0, 1'b1, "R1 rout over");
        do_insert(53, 0, 0, 0, 3, 0, 1'b1, "R1 mwr over");
        for (int t = 50; t <= 53; t++) lookup(t, 0, 0, 0, 0, 0, 1'b0, "R1 not stored");
        do_insert(60, 4, 4, 5, 2, 3, 1'b0, "R1 at limits");
        lookup(60, 4, 4, 3, 0, 0, 1'b1, "R1 full entry");
        replay_check(60, 5, 2, 3, "R4 full");

        // R5 stall
        rp_ready = 0;
        lookup(20, 2, 1, 5, 0, 0, 1'b1, "R5 hit");
        for (int c = 0; c < 3; c++) begin
            chk(lk_ready == 1'b0, "R5 ready low", 64'(lk_ready), 64'd0);
            chk(rp_ridx == f_oi(20, 0) && rp_data == f_ov(20, 0, 5), "R5 hold",
                64'(rp_data), 64'(f_ov(20, 0, 5)));
            set_lookup(60, 4, 4, 3, 0, 0);
            lk_valid = 1;
            @(negedge clk);
            chk(res_valid == 1'b0, "R5 no accept", 64'(res_valid), 64'd0);
        end
        lk_valid = 0;
        rp_ready = 1;
        replay_check(20, 3, 2, 5, "R5 resume");

        // R7 overwrite
        do_insert(20, 2, 1, 1, 1, 9, 1'b0, "R7");
        lookup(20, 2, 1, 9, 0, 0, 1'b1, "R7 new inputs");
        replay_check(20, 1, 1, 9, "R7 new outputs");
        lookup(20, 2, 1, 5, 0, 0, 1'b0, "R7 old inputs");

        // R8 empty write list
        do_insert(70, 1, 1, 0, 0, 2, 1'b0, "R8");
        lookup(70, 1, 1, 2, 0, 0, 1'b1, "R8 hit");
        chk(rp_valid == 1'b0, "R8 no replay", 64'(rp_valid), 64'd0);
        chk(lk_ready == 1'b1, "R8 ready", 64'(lk_ready), 64'd1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule